// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block is a stand-alone arithmetic engine that sits beside the main ALU and computes 32-bit products and quotients over many clock cycles instead of in one wide combinational array. A multiply accumulates the multiplicand into a running upper half and shifts one multiplier bit per cycle. A divide shifts the partial remainder left by one bit per cycle, subtracts the divisor as a trial, and keeps or discards the difference depending on the outcome. Both kinds of operation share one iteration engine and one controller, so both take the same fixed number of cycles.

A request is a one-cycle `start` together with an operation select, a signedness select and two operands. The unit reports `busy` while it works and raises `done` for one cycle when the two result registers, `hi` and `lo`, hold the new value. Signed requests are turned into magnitudes first, and the signs are put back on the result at the end. The controller has four states. IDLE waits for start and takes the accept transition to PREP, which captures the operands. PREP loads the magnitudes into the engine and takes the load transition to RUN. RUN performs one iteration per cycle and takes the last-step transition to FIX after the 32nd iteration. FIX writes the signed results into `hi` and `lo`, pulses `done` and takes the retire transition back to IDLE.

Top module: `muldiv_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: A `start` sampled at clock edge k while `busy` is 0 is accepted: `busy` is 1 after edges k through k+33, and after edge k+34 `done` is 1 and `busy` is 0 (35 edges from start to done, counting edge k), for multiply and for divide alike.
- R3: With `op_div`=0 and `op_signed`=0, {`hi`,`lo`} is the 64-bit unsigned product of `opa` and `opb` (`hi` is bits 63..32, `lo` is bits 31..0).
- R4: With `op_div`=0 and `op_signed`=1, {`hi`,`lo`} is the 64-bit two's-complement product of the operands taken as signed values.
- R5: With `op_div`=1, `op_signed`=0 and `opb` nonzero, `lo` is the unsigned quotient `opa`/`opb` and `hi` is the remainder.
- R6: With `op_div`=1, `op_signed`=1 and `opb` nonzero, the quotient in `lo` is truncated toward zero and the remainder in `hi` carries the sign of the dividend; the quotient of the most negative value by -1 is reported as its low 32 bits (0x80000000) with remainder 0.
- R7: A divide with `opb` equal to zero completes with the normal latency, with `lo` all ones and `hi` equal to `opa`, in both signed and unsigned modes.
- R8: A `start` seen while `busy` is 1 is ignored: the running operation's result is unchanged and no extra `done` pulse follows.
- R9: `done` is high for exactly one cycle per accepted request, and `hi` and `lo` keep their value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| op_signed | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when new results are in `hi` and `lo` |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |

## Verification
The hardest situation to reach from the ports is a second `start` arriving mid-operation with different operands, because only the absence of effects shows that it was dropped. The stimulus raises `start` for several cycles in the middle of a running divide with unrelated operands, then checks that the scoreboard receives exactly one result, equal to the first request's, and that no extra `done` appears. Sign fix-up corners, such as the most negative dividend over -1, a negative dividend over zero and mixed-sign remainders, are driven as directed cases, and random operands in all four modes follow.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIX  = 2'd3
    } md_state_e;

    typedef enum logic {
        KIND_MUL = 1'b0,
        KIND_DIV = 1'b1
    } md_kind_e;

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic init_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    md_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PREP;
            ST_PREP: state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST_STEP) state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, step counter and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIX);
            if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        accept_o = 1'b0;
        init_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_PREP: init_o   = 1'b1;
            ST_RUN:  step_o   = 1'b1;
            ST_FIX:  finish_o = 1'b1;
            default: busy_o   = 1'b0;
        endcase
    end

    assign done_o = done_q;

    assert_accept_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);

    assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/md_magnitude.sv
module md_magnitude #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = signed_i & val_i[W-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/md_engine.sv
module md_engine
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         step_i,
    input  md_kind_e     kind_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic [W-1:0] upper_o,
    output logic [W-1:0] lower_o
);
    // upper: running product half / partial remainder
    // lower: multiplier bits / dividend bits then quotient bits
    // oper : multiplicand / divisor
    logic [W-1:0] upper_q, lower_q, oper_q;
    logic [W-1:0] upper_d, lower_d;

    logic [W:0]   sum;
    logic [W:0]   shifted;
    logic [W-1:0] trial;
    logic         fits;

    always_comb begin
        sum     = {1'b0, upper_q} + (lower_q[0] ? {1'b0, oper_q} : '0);
        shifted = {upper_q, lower_q[W-1]};
        trial   = shifted[W-1:0] - oper_q;
        fits    = (shifted >= {1'b0, oper_q});
        if (kind_i == KIND_MUL) begin
            upper_d = sum[W:1];
            lower_d = {sum[0], lower_q[W-1:1]};
        end else if (fits) begin
            upper_d = trial;
            lower_d = {lower_q[W-2:0], 1'b1};
        end else begin
            upper_d = shifted[W-1:0];
            lower_d = {lower_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            oper_q  <= '0;
        end else if (init_i) begin
            upper_q <= '0;
            if (kind_i == KIND_MUL) begin
                lower_q <= mag_b_i;
                oper_q  <= mag_a_i;
            end else begin
                lower_q <= mag_a_i;
                oper_q  <= mag_b_i;
            end
        end else if (step_i) begin
            upper_q <= upper_d;
            lower_q <= lower_d;
        end
    end

    assign upper_o = upper_q;
    assign lower_o = lower_q;

    // restoring division keeps the partial remainder below a nonzero divisor
    assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_i) && kind_i == KIND_DIV && oper_q != '0) |-> (upper_q < oper_q));

endmodule

// File: rtl/md_fixup.sv
module md_fixup
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_kind_e     kind_i,
    input  logic         neg_a_i,
    input  logic         neg_b_i,
    input  logic         zero_div_i,
    input  logic [W-1:0] raw_hi_i,
    input  logic [W-1:0] raw_lo_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] prod;

    always_comb begin
        prod = {raw_hi_i, raw_lo_i};
        if (neg_a_i ^ neg_b_i) prod = ~prod + 1'b1;
        if (kind_i == KIND_MUL) begin
            hi_o = prod[W2-1:W];
            lo_o = prod[W-1:0];
        end else begin
            // remainder follows the dividend's sign
            hi_o = neg_a_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
            if (zero_div_i)                lo_o = '1;
            else if (neg_a_i ^ neg_b_i)    lo_o = ~raw_lo_i + 1'b1;
            else                           lo_o = raw_lo_i;
        end
    end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic         op_signed,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int LATENCY = W + 3;
    localparam int LAT_W   = $clog2(LATENCY + 1);

    logic accept, init, step, finish;

    md_kind_e     kind_q;
    logic         sgn_q;
    logic [W-1:0] a_q, b_q;
    logic [W-1:0] hi_q, lo_q;

    md_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .accept_o (accept),
        .init_o   (init),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy),
        .done_o   (done)
    );

    // request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_MUL;
            sgn_q  <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else if (accept) begin
            kind_q <= md_kind_e'(op_div);
            sgn_q  <= op_signed;
            a_q    <= opa;
            b_q    <= opb;
        end
    end

    // operand magnitudes
    logic [W-1:0] opnd [2];
    logic [W-1:0] mag  [2];
    logic         neg  [2];

    assign opnd[0] = a_q;
    assign opnd[1] = b_q;

    for (genvar g = 0; g < 2; g++) begin : g_mag
        md_magnitude #(.W(W)) u_mag (
            .val_i    (opnd[g]),
            .signed_i (sgn_q),
            .mag_o    (mag[g]),
            .neg_o    (neg[g])
        );
    end

    logic [W-1:0] raw_hi, raw_lo, fix_hi, fix_lo;
    logic         zero_div;

    assign zero_div = (b_q == '0);

    md_engine #(.W(W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init),
        .step_i  (step),
        .kind_i  (kind_q),
        .mag_a_i (mag[0]),
        .mag_b_i (mag[1]),
        .upper_o (raw_hi),
        .lower_o (raw_lo)
    );

    md_fixup #(.W(W)) u_fixup (
        .kind_i     (kind_q),
        .neg_a_i    (neg[0]),
        .neg_b_i    (neg[1]),
        .zero_div_i (zero_div),
        .raw_hi_i   (raw_hi),
        .raw_lo_i   (raw_lo),
        .hi_o       (fix_hi),
        .lo_o       (fix_lo)
    );

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finish) begin
            hi_q <= fix_hi;
            lo_q <= fix_lo;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    // latency observer for the assertion below
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (accept) lat_q <= LAT_W'(1);
        else if (busy)   lat_q <= lat_q + 1'b1;
    end

    assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LAT_W'(LATENCY)));

    assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(kind_q) && $stable(sgn_q)));

    assert_div_zero_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == KIND_DIV && b_q == '0) |-> (lo_q == '1 && hi_q == a_q));

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q != $past(hi_q) || lo_q != $past(lo_q)) |-> done);

endmodule

// File: tb/muldiv_seq_tb_top.sv
module muldiv_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        op_signed = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    muldiv_seq #(.W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .op_signed(op_signed), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] exp_hi[$];
    logic [31:0] exp_lo[$];
    int          exp_acc[$];
    string       exp_tag[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] model(input bit dv, input bit sg,
                                          input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] res;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!dv) begin
            if (sg) res = 64'(sa * sb);
            else    res = {32'b0, a} * {32'b0, b};
        end else if (b == 32'd0) begin
            res = {a, 32'hFFFF_FFFF};
        end else if (sg) begin
            q = sa / sb;
            r = sa % sb;
            res = {r[31:0], q[31:0]};
        end else begin
            res = {a % b, a / b};
        end
        return res;
    endfunction

    task automatic issue(input bit dv, input bit sg, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [63:0] e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = model(dv, sg, a, b);
        exp_hi.push_back(e[63:32]);
        exp_lo.push_back(e[31:0]);
        exp_acc.push_back(cyc + 1);
        exp_tag.push_back(tag);
        op_div = dv; op_signed = sg; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_hi.size() != 0 || busy) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_hi.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
            end else begin
                logic [31:0] eh, el;
                int ea;
                string t;
                eh = exp_hi.pop_front();
                el = exp_lo.pop_front();
                ea = exp_acc.pop_front();
                t  = exp_tag.pop_front();
                chk({hi, lo} == {eh, el}, t, "hi:lo result", {hi, lo}, {eh, el});
                chk(cyc - ea == GAP, "R2", "edges from accept to done",
                    64'(cyc - ea), 64'(GAP));
                chk(!busy, "R2", "busy low with done", 64'(busy), 64'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_hi, hold_lo;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && hi == '0 && lo == '0, "R1", "state in reset",
            {30'b0, busy, done, hi}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && lo == '0, "R1", "state after reset",
            {31'b0, busy, lo}, 64'd0);

        // R3 unsigned multiply
        issue(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        issue(1'b0, 1'b0, 32'd0, 32'h1234_5678, "R3");
        issue(1'b0, 1'b0, 32'h8000_0000, 32'd2, "R3");
        // R4 signed multiply
        issue(1'b0, 1'b1, 32'hFFFF_FFFF, 32'd7, "R4");
        issue(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R4");
        issue(1'b0, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
        // R5 unsigned divide
        issue(1'b1, 1'b0, 32'd100, 32'd7, "R5");
        issue(1'b1, 1'b0, 32'hFFFF_FFFF, 32'd1, "R5");
        issue(1'b1, 1'b0, 32'd5, 32'hFFFF_FFFF, "R5");
        // R6 signed divide
        issue(1'b1, 1'b1, 32'hFFFF_FFF9, 32'd2, "R6");
        issue(1'b1, 1'b1, 32'd7, 32'hFFFF_FFFE, "R6");
        issue(1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        issue(1'b1, 1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6");
        // R7 divide by zero
        issue(1'b1, 1'b0, 32'hDEAD_BEEF, 32'd0, "R7");
        issue(1'b1, 1'b1, 32'hFFFF_FF00, 32'd0, "R7");
        issue(1'b1, 1'b1, 32'd0, 32'd0, "R7");
        drain();

        // R8 start while busy is ignored
        issue(1'b1, 1'b0, 32'd1000, 32'd33, "R8");
        repeat (5) @(negedge clk);
        op_div = 1'b0; opa = 32'h5555_5555; opb = 32'h0000_0003; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "still busy after ignored start", 64'(busy), 64'd1);
        drain();
        repeat (40) @(negedge clk);
        chk(exp_hi.size() == 0, "R8", "no pending result",
            64'(exp_hi.size()), 64'd0);

        // R9 hold after done
        hold_hi = hi; hold_lo = lo;
        repeat (4) @(negedge clk);
        chk(!done && hi == hold_hi && lo == hold_lo, "R9", "results held",
            {hi, lo}, {hold_hi, hold_lo});

        // random operands in all four modes
        for (int i = 0; i < 48; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = (i % 3 == 0) ? ($urandom() % 17) : $urandom();
            unique case (i % 4)
                0: issue(1'b0, 1'b0, ra, rb, "R3");
                1: issue(1'b0, 1'b1, ra, rb, "R4");
                2: issue(1'b1, 1'b0, ra, rb, (rb == 0) ? "R7" : "R5");
                default: issue(1'b1, 1'b1, ra, rb, (rb == 0) ? "R7" : "R6");
            endcase
        end
        drain();
        repeat (3) @(negedge clk);

        if (!ended) begin
            ended = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule